// File: doc/BRIEF.md
# GF(2^8) Vector Affine Transform Unit

This unit applies a bit-level affine map over GF(2) to every byte of a wide vector. The data input carries sixteen independent 8-bit vectors. The matrix input is split into 64-bit lanes, and each lane holds one 8x8 bit matrix. That matrix transforms all eight data bytes in the same lane. A single 8-bit constant is XORed into every result byte. The map covers bit permutations, bit-matrix multiplication and the affine step of byte S-boxes. An identity matrix with a zero constant returns the data unchanged.

A per-byte write mask is available in two styles. In merge style, an unselected byte takes its value from a passthrough vector. In zeroing style, an unselected byte becomes zero. The result is held in one output register behind a valid/ready handshake. An operation accepted on one clock edge appears on the next edge. The unit keeps one result per cycle streaming as long as the consumer keeps pace.

Top module: `gf8_affine_vec`

## Requirements
- R1: Bit i of result byte k is the XOR of two terms. The first is the parity of (matrix byte (7-i) of k's lane AND data byte k). Parity is 1 for an odd number of set bits. The second is bit i of `in_const`. Matrix byte n of lane j is `in_mtx[64*j+8*n +: 8]`, and data byte k is `in_data[8*k +: 8]`.
- R2: Data byte k uses the matrix of lane k/8 and only that lane. A zero matrix in one lane gives the constant in all eight bytes of that lane. The other lane is not affected.
- R3: `in_const` applies to all sixteen bytes. A lane value of 64'h0102040810204080 is the identity matrix: with a zero constant the output equals `in_data`.
- R4: `in_mode` 2'b00 and 2'b11 are unmasked. Every byte is written and `in_mask` has no effect.
- R5: `in_mode` 2'b01 is merge masking. Byte k is the computed value when `in_mask[k]` is 1. Otherwise byte k is `in_pass[8*k +: 8]`.
- R6: `in_mode` 2'b10 is zero masking. Byte k is the computed value when `in_mask[k]` is 1, and 8'h00 otherwise.
- R7: Suppose `in_valid` and `in_ready` are both high on a rising edge. Then `out_valid` is high after that edge and `out_data` carries that operation's result. `out_valid` falls after an edge where `out_ready` is high and nothing new is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `in_ready` is high in any cycle where the output register is empty, or where `out_ready` is high. This gives one accepted operation per cycle when the stream runs back to back.
- R10: While `rst_n` is low, `out_valid` is 0, `out_data` is all zero and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_data | input | 128 | Sixteen data bytes |
| in_mtx | input | 128 | One 8x8 bit matrix per 64-bit lane |
| in_const | input | 8 | Constant XORed into every byte |
| in_mode | input | 2 | 00/11 unmasked, 01 merge, 10 zeroing |
| in_mask | input | 16 | Per-byte select, bit k for byte k |
| in_pass | input | 128 | Merge source for unselected bytes |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result bytes |

## Verification
The bench builds the unit with its defaults: two 64-bit lanes and the mask logic present. With two lanes, a lane-local fault is visible. A wrong matrix row order, or the wrong lane's matrix, changes bytes on one side of the 64-bit boundary and not the other. With the mask logic present, the merge, zeroing and both unmasked encodings can all be reached in one build. Random stalls on `out_ready` during a streamed run exercise the hold, same-cycle refill and drain paths of the output register.

// File: rtl/gf8_affine_pkg.sv
package gf8_affine_pkg;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned LANE_BYTES = 8;
   localparam int unsigned LANE_W     = BYTE_W * LANE_BYTES;

   typedef enum logic [1:0] {
      MODE_ALL     = 2'b00,
      MODE_MERGE   = 2'b01,
      MODE_ZERO    = 2'b10,
      MODE_ALL_ALT = 2'b11
   } mask_mode_e;

   function automatic logic mode_is_masked(input logic [1:0] m);
      return (m == MODE_MERGE) || (m == MODE_ZERO);
   endfunction

endpackage

// File: rtl/gf8_affine_byte.sv
module gf8_affine_byte
   import gf8_affine_pkg::*;
(
   input  logic [LANE_W-1:0] mtx,
   input  logic [BYTE_W-1:0] x,
   input  logic [BYTE_W-1:0] c,
   output logic [BYTE_W-1:0] y
);

   for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      logic [BYTE_W-1:0] row;
      assign row  = mtx[(BYTE_W-1-i)*BYTE_W +: BYTE_W];
      assign y[i] = (^(row & x)) ^ c[i];
   end

endmodule

// File: rtl/gf8_affine_array.sv
module gf8_affine_array
   import gf8_affine_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   localparam int unsigned NUM_BYTES = NUM_LANES * LANE_BYTES,
   localparam int unsigned VEC_W     = NUM_BYTES * BYTE_W
)(
   input  logic [VEC_W-1:0]  data,
   input  logic [VEC_W-1:0]  mtx,
   input  logic [BYTE_W-1:0] cst,
   output logic [VEC_W-1:0]  res
);

   for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
      logic [LANE_W-1:0] lane_mtx;
      assign lane_mtx = mtx[j*LANE_W +: LANE_W];
      for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
         localparam int unsigned K = j*LANE_BYTES + b;
         gf8_affine_byte u_byte (
            .mtx (lane_mtx),
            .x   (data[K*BYTE_W +: BYTE_W]),
            .c   (cst),
            .y   (res[K*BYTE_W +: BYTE_W])
         );
      end
   end

endmodule

// File: rtl/gf8_mask_apply.sv
module gf8_mask_apply
   import gf8_affine_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 16,
   parameter bit          MASK_EN   = 1'b1,
   localparam int unsigned VEC_W    = NUM_BYTES * BYTE_W
)(
   input  logic [VEC_W-1:0]     res,
   input  logic [VEC_W-1:0]     pass,
   input  logic [NUM_BYTES-1:0] mask,
   input  logic [1:0]           mode,
   output logic [VEC_W-1:0]     out
);

   if (MASK_EN) begin : g_mask
      logic masked;
      assign masked = mode_is_masked(mode);
      for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
         always_comb begin
            if (!masked || mask[k])
               out[k*BYTE_W +: BYTE_W] = res[k*BYTE_W +: BYTE_W];
            else if (mode == MODE_MERGE)
               out[k*BYTE_W +: BYTE_W] = pass[k*BYTE_W +: BYTE_W];
            else
               out[k*BYTE_W +: BYTE_W] = '0;
         end
      end
   end else begin : g_nomask
      logic unused_mask_inputs;
      assign unused_mask_inputs = ^{pass, mask, mode};
      assign out = res;
   end

endmodule

// File: rtl/gf8_out_stage.sv
module gf8_out_stage #(
   parameter int unsigned W = 128
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] d,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] q
);

   logic         full_q;
   logic [W-1:0] data_q;
   logic         take;

   assign in_ready  = !full_q || out_ready;
   assign take      = in_valid && in_ready;
   assign out_valid = full_q;
   assign q         = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (take) begin
            full_q <= 1'b1;
            data_q <= d;
         end else if (out_ready) begin
            full_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/gf8_affine_vec.sv
module gf8_affine_vec
   import gf8_affine_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   parameter bit          MASK_EN   = 1'b1,
   localparam int unsigned NUM_BYTES = NUM_LANES * LANE_BYTES,
   localparam int unsigned VEC_W     = NUM_BYTES * BYTE_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [VEC_W-1:0]     in_data,
   input  logic [VEC_W-1:0]     in_mtx,
   input  logic [BYTE_W-1:0]    in_const,
   input  logic [1:0]           in_mode,
   input  logic [NUM_BYTES-1:0] in_mask,
   input  logic [VEC_W-1:0]     in_pass,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [VEC_W-1:0]     out_data
);

   if (NUM_LANES < 1 || NUM_LANES > 8) begin : g_bad_lanes
      $error("gf8_affine_vec: NUM_LANES must be 1..8");
   end

   logic [VEC_W-1:0] raw_res;
   logic [VEC_W-1:0] sel_res;

   gf8_affine_array #(.NUM_LANES(NUM_LANES)) u_array (
      .data (in_data),
      .mtx  (in_mtx),
      .cst  (in_const),
      .res  (raw_res)
   );

   gf8_mask_apply #(.NUM_BYTES(NUM_BYTES), .MASK_EN(MASK_EN)) u_mask (
      .res  (raw_res),
      .pass (in_pass),
      .mask (in_mask),
      .mode (in_mode),
      .out  (sel_res)
   );

   gf8_out_stage #(.W(VEC_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .d         (sel_res),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .q         (out_data)
   );

endmodule

// File: rtl/gf8_affine_chk.sv
module gf8_affine_chk
   import gf8_affine_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   localparam int unsigned NUM_BYTES = NUM_LANES * LANE_BYTES,
   localparam int unsigned VEC_W     = NUM_BYTES * BYTE_W
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic [1:0]           in_mode,
   input logic [NUM_BYTES-1:0] in_mask,
   input logic [VEC_W-1:0]     in_pass,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [VEC_W-1:0]     out_data
);

   logic             acc;
   logic [VEC_W-1:0] in_keep;
   logic [VEC_W-1:0] lat_keep;
   logic [VEC_W-1:0] lat_pass;
   logic [1:0]       lat_mode;

   assign acc = in_valid && in_ready;

   always_comb begin
      for (int k = 0; k < NUM_BYTES; k++)
         in_keep[k*BYTE_W +: BYTE_W] = {BYTE_W{in_mask[k]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_keep <= '1;
         lat_pass <= '0;
         lat_mode <= MODE_ALL;
      end else if (acc) begin
         lat_keep <= in_keep;
         lat_pass <= in_pass;
         lat_mode <= in_mode;
      end
   end

   // R5: merge masking fills unselected bytes from the passthrough
   a_r5_merge_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lat_mode == MODE_MERGE) |-> (((out_data ^ lat_pass) & ~lat_keep) == '0));

   // R6: zero masking clears unselected bytes
   a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lat_mode == MODE_ZERO) |-> ((out_data & ~lat_keep) == '0));

   // R7: accepted operation shows up one edge later
   a_r7_accept_lat: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);

   // R7: a consumed result with no refill empties the register
   a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !acc) |=> !out_valid);

   // R8: stalled result is held
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9: empty register always accepts
   a_r9_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R10: first cycle out of reset starts empty
   a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && out_data == '0));

endmodule

bind gf8_affine_vec gf8_affine_chk #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_mode   (in_mode),
   .in_mask   (in_mask),
   .in_pass   (in_pass),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/gf8_affine_vec_bench.sv
`timescale 1ns/1ps
module gf8_affine_vec_bench;

   localparam int NB = 16;
   localparam int VW = 128;
   localparam logic [63:0] IDM = 64'h0102040810204080;

   typedef struct packed {
      logic [VW-1:0] d;
      logic [VW-1:0] m;
      logic [7:0]    c;
      logic [1:0]    mode;
      logic [NB-1:0] mask;
      logic [VW-1:0] p;
   } vec_t;

   localparam int NT = 8;
   localparam vec_t TBL [NT] = '{
      '{128'h00112233445566778899AABBCCDDEEFF, {IDM, IDM}, 8'h00, 2'b00, 16'h0000, 128'h0},
      '{128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, {IDM, IDM}, 8'hA5, 2'b00, 16'h0000, 128'h0},
      '{128'hDEADBEEFCAFEF00D0123456789ABCDEF, {64'h0, IDM}, 8'h00, 2'b00, 16'h0000, 128'h0},
      '{128'h13579BDF2468ACE0FEDCBA9876543210, {64'h8F1F3F7FFEFCF8F1, 64'hF1E3C78F1F3E7CF8}, 8'h63, 2'b01, 16'h00FF, 128'hAAAAAAAAAAAAAAAA5555555555555555},
      '{128'hA1B2C3D4E5F60718293A4B5C6D7E8F90, {64'h1122448811224488, 64'h8040201008040201}, 8'h3C, 2'b10, 16'hA5C3, 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF},
      '{128'h55AA55AA00FF00FF1234567890ABCDEF, {64'h0F0F0F0FF0F0F0F0, 64'h8142241818244281}, 8'h1D, 2'b11, 16'h0000, 128'h77777777777777777777777777777777},
      '{128'h0102040810204080FF7F3F1F0F070301, {64'h3355AA0F3355AA0F, 64'hC3C3C3C35A5A5A5A}, 8'hE7, 2'b00, 16'h0000, 128'h12121212121212121212121212121212},
      '{128'h010307FF00FE80C0E0F0F8FC7E3C1800, {64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}, 8'h00, 2'b00, 16'h0000, 128'h0}
   };
   localparam string TAGS [NT] = '{"R3", "R3", "R2", "R5", "R6", "R4", "R4", "R1"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [VW-1:0] in_data = '0;
   logic [VW-1:0] in_mtx = '0;
   logic [7:0]    in_const = '0;
   logic [1:0]    in_mode = '0;
   logic [NB-1:0] in_mask = '0;
   logic [VW-1:0] in_pass = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [VW-1:0] out_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gf8_affine_vec u_gf8_affine_vec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_mtx(in_mtx), .in_const(in_const), .in_mode(in_mode),
      .in_mask(in_mask), .in_pass(in_pass), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [VW-1:0] model(vec_t v);
      logic [VW-1:0] r;
      for (int k = 0; k < NB; k++) begin
         logic [7:0] b;
         int lane = k / 8;
         for (int i = 0; i < 8; i++) begin
            logic [7:0] row = v.m[lane*64 + (7-i)*8 +: 8];
            b[i] = logic'($countones(row & v.d[k*8 +: 8]) % 2) ^ v.c[i];
         end
         if ((v.mode == 2'b01 || v.mode == 2'b10) && !v.mask[k])
            b = (v.mode == 2'b01) ? v.p[k*8 +: 8] : 8'h00;
         r[k*8 +: 8] = b;
      end
      return r;
   endfunction

   task automatic chk(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic drive(vec_t v);
      in_data = v.d; in_mtx = v.m; in_const = v.c;
      in_mode = v.mode; in_mask = v.mask; in_pass = v.p;
   endtask

   function automatic vec_t rnd_vec();
      vec_t v;
      v.d = {$urandom, $urandom, $urandom, $urandom};
      v.m = {$urandom, $urandom, $urandom, $urandom};
      v.p = {$urandom, $urandom, $urandom, $urandom};
      v.c = 8'($urandom);
      v.mode = 2'($urandom);
      v.mask = 16'($urandom);
      return v;
   endfunction

   // single operation: accept on one edge, check at the following negedge
   task automatic do_op(vec_t v, string tag);
      @(negedge clk);
      drive(v);
      in_valid = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, {tag, " R7 valid"}, VW'(out_valid), VW'(1));
      chk(out_data == model(v), tag, out_data, model(v));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      finish_run();
   end

   initial begin : main
      vec_t v0, v1, v2;
      logic [VW-1:0] held;
      logic [VW-1:0] exp_q[$];

      // R10 reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid", VW'(out_valid), VW'(0));
      chk(out_data == '0, "R10 out_data", out_data, '0);
      chk(in_ready == 1'b1, "R10 in_ready", VW'(in_ready), VW'(1));
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 after release", VW'(out_valid), VW'(0));

      // table walk
      for (int t = 0; t < NT; t++) do_op(TBL[t], TAGS[t]);

      // R3 identity returns data unchanged (explicit value check)
      do_op(TBL[0], "R3 identity");
      chk(out_data == TBL[0].d, "R3 identity data", out_data, TBL[0].d);

      // R4: mask ignored in unmasked modes, same operands with different masks
      v0 = TBL[6]; v0.mask = 16'h0000; v0.mode = 2'b00;
      do_op(v0, "R4 mode00 mask0");
      held = out_data;
      v0.mask = 16'h5A5A;
      do_op(v0, "R4 mode00 mask5A5A");
      chk(out_data == held, "R4 mask no effect 00", out_data, held);
      v0.mode = 2'b11;
      do_op(v0, "R4 mode11 mask5A5A");
      chk(out_data == held, "R4 mask no effect 11", out_data, held);

      // R1 random single operations
      for (int n = 0; n < 40; n++) do_op(rnd_vec(), "R1 random");

      // R8/R9 stall, hold and same-cycle refill
      v1 = rnd_vec(); v2 = rnd_vec();
      @(negedge clk);
      drive(v1); in_valid = 1'b1; out_ready = 1'b0;
      @(negedge clk);
      drive(v2);
      chk(out_valid == 1'b1, "R7 stalled valid", VW'(out_valid), VW'(1));
      held = out_data;
      chk(held == model(v1), "R7 stalled data", held, model(v1));
      for (int s = 0; s < 3; s++) begin
         chk(in_ready == 1'b0, "R9 full not ready", VW'(in_ready), VW'(0));
         @(negedge clk);
         chk(out_valid == 1'b1 && out_data == held, "R8 hold", out_data, held);
      end
      out_ready = 1'b1;
      #0.5;
      chk(in_ready == 1'b1, "R9 ready when consumed", VW'(in_ready), VW'(1));
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1 && out_data == model(v2), "R9 refill", out_data, model(v2));
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 drain", VW'(out_valid), VW'(0));

      // R9 streaming with random stalls against the model
      for (int cyc = 0; cyc < 400; cyc++) begin
         vec_t vs;
         vs = rnd_vec();
         drive(vs);
         in_valid = ($urandom % 4) != 0;
         out_ready = ($urandom % 3) != 0;
         #0.5;
         if (out_valid && out_ready) begin
            logic [VW-1:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : ~out_data;
            chk(out_data == e, "R9 stream", out_data, e);
         end
         if (in_valid && in_ready) exp_q.push_back(model(vs));
         @(negedge clk);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      if (exp_q.size() > 0) begin
         chk(out_data == exp_q[0], "R9 stream tail", out_data, exp_q[0]);
         void'(exp_q.pop_front());
      end
      chk(exp_q.size() == 0, "R9 stream drained", VW'(exp_q.size()), VW'(0));

      finish_run();
   end

endmodule